// File: doc/BRIEF.md
# Latched Sink-Output Serial Register

This block is a serial-in, parallel-out register that drives a row of open-drain sink outputs, with a separate holding stage between the shift path and the pins. A controller shifts a word in one bit at a time with a slow shift-clock pin. It then pulses a latch-clock pin, and the whole word is copied onto the outputs at once. The pins do not flicker while the next word is loaded. A serial output carries the last shift stage, so several of these blocks can be chained on one data line.

All pin inputs are asynchronous to the system clock. They are synchronised first and then edge-detected. The latch clock also goes through a noise filter, so a short spike cannot cause a transfer. Each output is modelled two ways: a pull-down enable per pin, and the level that pin would show with its external pull-up. An active-low reset input stands in for a supply-monitor reset.

Top module: `sink_latch_driver`

## Requirements
- R1: Each rising edge on `sclk_pin` shifts the register once (12 stages by default). Stage 0 takes `sdata_pin` and stage k takes the old stage k-1. After 12 shifts, the first bit sent sits in stage 11.
- R2: A filtered rising edge on `lclk_pin` copies all shift stages into the holding stage. At all other times the holding stage keeps its value, so shifting alone never changes `sink_en` or `pin_lvl`.
- R3: With `out_off` low, `sink_en[i]` is 1 exactly when holding bit i is 0, and `pin_lvl[i]` is the inverse of `sink_en[i]`. So `pin_lvl` equals the holding stage, bit for bit.
- R4: With `out_off` high, every `sink_en` bit is 0 and every `pin_lvl` bit is 1, whatever the holding stage contains. Dropping `out_off` brings back the held word, including any word latched while the outputs were off. The synchronised disable resets to 0, so the outputs come up enabled, as a pulled-down enable pin would leave them.
- R5: `sout` equals shift stage 11. It changes only on a shift, and `out_off` has no effect on it.
- R6: A latch-clock level is accepted only after `lclk_pin` has held it for FILT_CYC consecutive system clocks (default 3). A high pulse of 2 clocks causes no transfer. A pulse of 3 or more clocks causes exactly one transfer.
- R7: A low `rst_n` clears the shift and holding stages. After reset, `sout` is 0, `sink_en` is all ones and `pin_lvl` is all zeros.
- R8: Holding `sclk_pin` high for many system clocks produces only one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pin inputs |
| rst_n | input | 1 | Asynchronous active-low reset, stand-in for the supply monitor |
| sclk_pin | input | 1 | Shift clock; its rising edge shifts once |
| sdata_pin | input | 1 | Serial data entering stage 0 |
| lclk_pin | input | 1 | Latch clock; a filtered rising edge loads the holding stage |
| out_off | input | 1 | High turns every sink off |
| sink_en | output | W | Pull-down enable for each output pin |
| pin_lvl | output | W | Level of each pin, given an external pull-up |
| sout | output | 1 | Last shift stage, for cascading |

## Verification
The assertions assume a few things about the inputs:
- `sclk_pin` and `sdata_pin` change far more slowly than `clk`.
- `sdata_pin` is steady through the synchroniser delay around each shift-clock rise.
- `sclk_pin` stays low for at least one sampled clock between rises, so the one-cycle edge pulse can be judged alone.

The stimulus changes pins only on falling `clk` edges. It holds each shift-clock phase for four system clocks and keeps the data steady across the whole high phase. Latch pulses are either clearly shorter than the filter length or at least as long, and a dozen quiet clocks pass before any result is compared.

// File: rtl/sink_pkg.sv
package sink_pkg;
  localparam int SINK_W_DEF = 12;
  localparam int FILT_DEF   = 3;
  localparam int SYNC_DEF   = 2;

  // True when a level that has already differed for `run` cycles
  // is accepted on the current cycle.
  function automatic logic filt_accept(input int unsigned run, input int unsigned lim);
    return (run + 1) >= lim;
  endfunction
endpackage

// File: rtl/sink_sync.sv
module sink_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sink_glitch_filter.sv
module sink_glitch_filter import sink_pkg::*; #(
  parameter int FILT_CYC = FILT_DEF,
  parameter int SYNC     = SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic sync_lvl,
  output logic filt,
  output logic rise
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          filt_q;
  logic          filt_d1;
  logic [CW-1:0] run_q;
  logic          differ;

  sink_sync #(.STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (sync_lvl)
  );

  assign differ = (sync_lvl != filt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (!differ) begin
      run_q  <= '0;
    end else if (filt_accept(int'(run_q), FILT_CYC)) begin
      filt_q <= sync_lvl;
      run_q  <= '0;
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_d1 <= 1'b0;
    else        filt_d1 <= filt_q;
  end

  assign filt = filt_q;
  assign rise = filt_q & ~filt_d1;
endmodule

// File: rtl/sink_shift_chain.sv
module sink_shift_chain #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  generate
    for (genvar g = 0; g < W; g++) begin : g_stage
      logic nxt;
      if (g == 0) begin : g_head
        assign nxt = din;
      end else begin : g_body
        assign nxt = q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q[g] <= 1'b0;
        else if (shift) q[g] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/sink_latch_driver.sv
module sink_latch_driver import sink_pkg::*; #(
  parameter int W        = SINK_W_DEF,
  parameter int FILT_CYC = FILT_DEF,
  parameter int SYNC     = SYNC_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_pin,
  input  logic         sdata_pin,
  input  logic         lclk_pin,
  input  logic         out_off,
  output logic [W-1:0] sink_en,
  output logic [W-1:0] pin_lvl,
  output logic         sout
);
  // Internal events, brought out by name for the checker.
  logic         sclk_s;
  logic         sclk_d1;
  logic         sdata_s;
  logic         shift_rise;
  logic         lat_sync;
  logic         lat_filt;
  logic         lat_rise;
  logic         off_s;
  logic [W-1:0] shreg;
  logic [W-1:0] store;

  function automatic logic [W-1:0] drive_sinks(input logic [W-1:0] held, input logic off);
    return off ? '0 : ~held;
  endfunction

  sink_sync #(.STAGES(SYNC)) u_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk_pin), .q(sclk_s)
  );
  sink_sync #(.STAGES(SYNC)) u_sdata (
    .clk(clk), .rst_n(rst_n), .d(sdata_pin), .q(sdata_s)
  );
  sink_sync #(.STAGES(SYNC)) u_off (
    .clk(clk), .rst_n(rst_n), .d(out_off), .q(off_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d1 <= 1'b0;
    else        sclk_d1 <= sclk_s;
  end
  assign shift_rise = sclk_s & ~sclk_d1;

  sink_shift_chain #(.W(W)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (shift_rise),
    .din   (sdata_s),
    .q     (shreg)
  );

  sink_glitch_filter #(.FILT_CYC(FILT_CYC), .SYNC(SYNC)) u_lfilt (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (lclk_pin),
    .sync_lvl (lat_sync),
    .filt     (lat_filt),
    .rise     (lat_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        store <= '0;
    else if (lat_rise) store <= shreg;
  end

  assign sink_en = drive_sinks(store, off_s);
  assign pin_lvl = ~sink_en;
  assign sout    = shreg[W-1];
endmodule

// File: rtl/sink_latch_checker.sv
module sink_latch_checker #(
  parameter int W        = 12,
  parameter int FILT_CYC = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_rise,
  input logic         lat_rise,
  input logic         lat_sync,
  input logic         lat_filt,
  input logic         off_s,
  input logic [W-1:0] shreg,
  input logic [W-1:0] store,
  input logic [W-1:0] sink_en,
  input logic [W-1:0] pin_lvl,
  input logic         sout
);
  // R1: stages move only on a shift, and then by one place
  a_r1_no_stray_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise |=> $stable(shreg));
  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> shreg[W-1:1] == $past(shreg[W-2:0]));

  // R2: holding stage loads on a filtered edge and holds otherwise
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> $stable(store));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> store == $past(shreg));

  // R3: enabled pins follow the holding stage
  a_r3_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !off_s |-> pin_lvl == store);

  // R4: disable turns every sink off
  a_r4_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    off_s |-> (sink_en == '0) && (pin_lvl == '1));

  // R5: serial output moves only with a shift
  a_r5_sout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise |=> $stable(sout));

  // R6: a filtered level change takes the level the synchroniser saw
  a_r6_filt_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat_filt) |-> lat_filt == $past(lat_sync));
  generate
    if (FILT_CYC >= 2) begin : g_two
      a_r6_filt_two: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_filt) |-> lat_filt == $past(lat_sync, 2));
    end
  endgenerate

  // R8: a held shift clock yields a lone pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> !shift_rise);
endmodule

bind sink_latch_driver sink_latch_checker #(.W(W), .FILT_CYC(FILT_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_rise (shift_rise),
  .lat_rise   (lat_rise),
  .lat_sync   (lat_sync),
  .lat_filt   (lat_filt),
  .off_s      (off_s),
  .shreg      (shreg),
  .store      (store),
  .sink_en    (sink_en),
  .pin_lvl    (pin_lvl),
  .sout       (sout)
);

// File: tb/sim_sink_latch_driver.sv
module sim_sink_latch_driver;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_pin = 1'b0;
  logic sdata_pin = 1'b0;
  logic lclk_pin = 1'b0;
  logic out_off = 1'b0;
  logic [W-1:0] sink_en;
  logic [W-1:0] pin_lvl;
  logic sout;

  always #10 clk = ~clk;

  sink_latch_driver #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .sdata_pin(sdata_pin),
    .lclk_pin(lclk_pin), .out_off(out_off),
    .sink_en(sink_en), .pin_lvl(pin_lvl), .sout(sout)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] sink;
    logic [W-1:0] pin;
    logic         so;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // Bench model, written from the requirements
  logic [W-1:0] m_sh = '0;
  logic [W-1:0] m_st = '0;
  logic         m_off = 1'b0;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string tag);
    exp_t e;
    wait_n(12);
    e.tag  = tag;
    e.sink = m_off ? '0 : ~m_st;
    e.pin  = m_off ? '1 : m_st;
    e.so   = m_sh[W-1];
    q.push_back(e);
    wait_n(1);
  endtask

  task automatic shift_bit(input logic d, input int high_cyc);
    sdata_pin = d;
    wait_n(4);
    sclk_pin = 1'b1;
    wait_n(high_cyc);
    sclk_pin = 1'b0;
    wait_n(4);
    m_sh = {m_sh[W-2:0], d};
  endtask

  task automatic shift_word(input logic [W-1:0] w, input string tag);
    for (int i = W - 1; i >= 0; i--) begin
      shift_bit(w[i], 4);
      push(tag);
    end
  endtask

  task automatic latch_pulse(input int width, input bit accepted);
    lclk_pin = 1'b1;
    wait_n(width);
    lclk_pin = 1'b0;
    if (accepted) m_st = m_sh;
  endtask

  // Monitor: compare each expected item as it arrives
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      vectors++;
      if (sink_en !== e.sink) begin
        fails++;
        $display("FAIL %s sink_en act=%h exp=%h", e.tag, sink_en, e.sink);
      end
      if (pin_lvl !== e.pin) begin
        fails++;
        $display("FAIL %s pin_lvl act=%h exp=%h", e.tag, pin_lvl, e.pin);
      end
      if (sout !== e.so) begin
        fails++;
        $display("FAIL %s sout act=%b exp=%b", e.tag, sout, e.so);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    push("R7 reset state");
    rst_n = 1'b1;
    wait_n(3);

    // R1 and R5: shift a word; R2: pins hold during shifting
    shift_word(12'hA5C, "R1 R5 shift word A");
    latch_pulse(6, 1'b1);
    push("R2 R3 latch word A");

    // R8: one long high phase counts as one shift
    shift_bit(1'b1, 40);
    push("R8 held shift clock");
    shift_word(12'h3C9, "R2 pins hold while shifting");

    // R6: a 2-clock spike is rejected, a 3-clock pulse is taken
    latch_pulse(2, 1'b0);
    push("R6 short spike rejected");
    latch_pulse(3, 1'b1);
    push("R6 minimum pulse accepted");

    // R4: disable, shift and latch while off, then enable
    out_off = 1'b1; m_off = 1'b1;
    push("R4 outputs off");
    shift_bit(1'b0, 4);
    push("R5 sout while off");
    latch_pulse(5, 1'b1);
    push("R4 latch while off");
    out_off = 1'b0; m_off = 1'b0;
    push("R4 outputs back on");

    shift_word(12'hFFF, "R1 all ones");
    latch_pulse(8, 1'b1);
    push("R3 all sinks off by data");

    // R7: reset in mid-operation
    rst_n = 1'b0;
    m_sh = '0; m_st = '0;
    wait_n(3);
    push("R7 reset mid run");
    rst_n = 1'b1;
    wait_n(3);
    shift_bit(1'b1, 4);
    push("R7 R1 shift after reset");

    wait (q.size() == 0);
    wait_n(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule